// File: doc/BRIEF.md
# Rotation Time to Track Position Converter

This block turns a free-running rotation time, counted in clock cycles, into a bit position on a circular track. A fixed lead time is added to the time first. The lead depends on the reason for the lookup: a fresh read start uses the longer lead, and a return to reading after a write uses the shorter one. The lead leaves room for the data path to fetch words before the position comes under the head.

The block does not divide by the bit period. It multiplies the time by a programmed reciprocal of the bit period, scaled by 2^32, and keeps the upper half of the 64-bit product. The result can run one track length past the end, so it is wrapped by at most one subtraction of the track bit length. The block then splits the position into a word offset and a bit inside that word, and it gives the number of whole track words from that word to the end of the track.

A single-cycle request pulse starts one conversion. The result appears two clock edges later with a one-cycle valid pulse. Requests may arrive on back-to-back cycles.

Top module: `rot_track_pos`

## Requirements
- R1: While reset is asserted and after it is released, `res_vld_o` is low and every result output is zero until the first result arrives.
- R2: A request sampled high on clock edge k gives `res_vld_o` high for exactly one cycle after edge k+1. Requests on consecutive cycles each give their own result on consecutive cycles.
- R3: The raw bit count equals the upper 32 bits of the 64-bit product (adjusted time × `inv_period_i`), where `inv_period_i` is the reciprocal of the bit period in clocks, scaled by 2^32.
- R4: The adjusted time is `rot_time_i` plus 1920 when `lead_sel_i` = 0 (read start) or plus 620 when `lead_sel_i` = 1 (resume after write), taken modulo 2^32.
- R5: If the raw bit count is greater than or equal to `track_bytes_i` × 8, that track bit length is subtracted once. Otherwise the count is passed through unchanged.
- R6: `word_off_o` equals `bit_pos_o` shifted right by 5, and `bit_in_word_o` equals `bit_pos_o` AND 31.
- R7: `words_left_o` equals (`track_bytes_i` / 4) minus `word_off_o`.
- R8: When no result is delivered, the result outputs keep their last values, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | One-cycle conversion request |
| lead_sel_i | input | 1 | Lead choice: 0 read start, 1 resume after write |
| rot_time_i | input | 32 | Current rotation time in clocks |
| inv_period_i | input | 32 | Reciprocal bit period scaled by 2^32 |
| track_bytes_i | input | 16 | Track length in bytes, a multiple of 4 |
| res_vld_o | output | 1 | Result valid pulse |
| bit_pos_o | output | 32 | Bit position in the track |
| word_off_o | output | 27 | Word offset from the start of the track |
| bit_in_word_o | output | 5 | Bit within the word |
| words_left_o | output | 14 | Track words from the offset word to the end |

## Verification
The checks take three things as given. First, `track_bytes_i` stays the same from a request until its result appears. Second, it is a multiple of 4. Third, the raw bit count is below twice the track bit length, so one subtraction always puts the position inside the track. The stimulus stays inside these limits. Every vector keeps the track length steady for its own request, including the back-to-back pair. Each reciprocal and time value is chosen so that the raw count either stays below one track length or passes it by only a little. The chosen values include the exact wrap boundary, the position one below it, a 32-bit overflow of the time sum, and the largest reciprocal.

// File: rtl/rot_track_pos_pkg.sv
package rot_track_pos_pkg;
  typedef enum logic {
    LEAD_READ   = 1'b0,
    LEAD_RESUME = 1'b1
  } lead_sel_e;
endpackage

// File: rtl/rtp_lead_add.sv
module rtp_lead_add #(
  parameter int TIME_W      = 32,
  parameter int READ_LEAD   = 1920,
  parameter int RESUME_LEAD = 620
) (
  input  logic              sel_i,
  input  logic [TIME_W-1:0] time_i,
  output logic [TIME_W-1:0] sum_o
);
  import rot_track_pos_pkg::*;

  localparam logic [TIME_W-1:0] READ_L   = TIME_W'(READ_LEAD);
  localparam logic [TIME_W-1:0] RESUME_L = TIME_W'(RESUME_LEAD);

  logic [TIME_W-1:0] lead;

  always_comb begin
    lead  = (lead_sel_e'(sel_i) == LEAD_RESUME) ? RESUME_L : READ_L;
    sum_o = time_i + lead;
  end
endmodule

// File: rtl/rtp_recip_mul.sv
module rtp_recip_mul #(
  parameter int TIME_W  = 32,
  parameter int FRAC_W  = 32,
  parameter int BYTES_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic [TIME_W-1:0]  time_i,
  input  logic [FRAC_W-1:0]  inv_i,
  input  logic [BYTES_W-1:0] bytes_i,
  output logic               vld_o,
  output logic [TIME_W-1:0]  cnt_o,
  output logic [BYTES_W-1:0] bytes_o
);
  localparam int PROD_W = TIME_W + FRAC_W;

  logic [PROD_W-1:0]  prod;
  logic [TIME_W-1:0]  cnt_n;
  logic [TIME_W-1:0]  cnt_q;
  logic [BYTES_W-1:0] bytes_q;
  logic               vld_q;

  always_comb begin
    prod  = PROD_W'(time_i) * PROD_W'(inv_i);
    cnt_n = TIME_W'(prod >> FRAC_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      cnt_q   <= '0;
      bytes_q <= '0;
    end else begin
      vld_q <= en_i;
      if (en_i) begin
        cnt_q   <= cnt_n;
        bytes_q <= bytes_i;
      end
    end
  end

  assign vld_o   = vld_q;
  assign cnt_o   = cnt_q;
  assign bytes_o = bytes_q;
endmodule

// File: rtl/rtp_wrap_split.sv
module rtp_wrap_split #(
  parameter int BIT_W   = 32,
  parameter int BYTES_W = 16,
  parameter int WORD_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic [BIT_W-1:0]    cnt_i,
  input  logic [BYTES_W-1:0]  bytes_i,
  output logic                vld_o,
  output logic [BIT_W-1:0]    pos_o,
  output logic [BIT_W-$clog2(WORD_W)-1:0] woff_o,
  output logic [$clog2(WORD_W)-1:0]       bit_o,
  output logic [BYTES_W-$clog2(WORD_W/8)-1:0] left_o
);
  localparam int WSH    = $clog2(WORD_W);
  localparam int BSH    = $clog2(WORD_W / 8);
  localparam int WOFF_W = BIT_W - WSH;
  localparam int LEFT_W = BYTES_W - BSH;

  logic [BIT_W-1:0]  trk_bits;
  logic [BIT_W-1:0]  pos_n;
  logic [WOFF_W-1:0] woff_n;
  logic [WSH-1:0]    bit_n;
  logic [WOFF_W-1:0] trk_words;
  logic [WOFF_W-1:0] left_full;
  logic [LEFT_W-1:0] left_n;

  logic              vld_q;
  logic [BIT_W-1:0]  pos_q;
  logic [WOFF_W-1:0] woff_q;
  logic [WSH-1:0]    bit_q;
  logic [LEFT_W-1:0] left_q;

  always_comb begin
    trk_bits  = BIT_W'(bytes_i) << 3;
    pos_n     = (cnt_i >= trk_bits) ? (cnt_i - trk_bits) : cnt_i;
    woff_n    = WOFF_W'(pos_n >> WSH);
    bit_n     = WSH'(pos_n);
    trk_words = WOFF_W'(bytes_i >> BSH);
    left_full = trk_words - woff_n;
    left_n    = LEFT_W'(left_full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      pos_q  <= '0;
      woff_q <= '0;
      bit_q  <= '0;
      left_q <= '0;
    end else begin
      vld_q <= en_i;
      if (en_i) begin
        pos_q  <= pos_n;
        woff_q <= woff_n;
        bit_q  <= bit_n;
        left_q <= left_n;
      end
    end
  end

  assign vld_o  = vld_q;
  assign pos_o  = pos_q;
  assign woff_o = woff_q;
  assign bit_o  = bit_q;
  assign left_o = left_q;
endmodule

// File: rtl/rot_track_pos.sv
module rot_track_pos #(
  parameter int TIME_W      = 32,
  parameter int FRAC_W      = 32,
  parameter int BYTES_W     = 16,
  parameter int WORD_W      = 32,
  parameter int READ_LEAD   = 1920,
  parameter int RESUME_LEAD = 620,
  localparam int WSH    = $clog2(WORD_W),
  localparam int WOFF_W = TIME_W - WSH,
  localparam int LEFT_W = BYTES_W - $clog2(WORD_W / 8)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic               lead_sel_i,
  input  logic [TIME_W-1:0]  rot_time_i,
  input  logic [FRAC_W-1:0]  inv_period_i,
  input  logic [BYTES_W-1:0] track_bytes_i,
  output logic               res_vld_o,
  output logic [TIME_W-1:0]  bit_pos_o,
  output logic [WOFF_W-1:0]  word_off_o,
  output logic [WSH-1:0]     bit_in_word_o,
  output logic [LEFT_W-1:0]  words_left_o
);
  logic [TIME_W-1:0]  adj_time;
  logic               mul_vld;
  logic [TIME_W-1:0]  mul_cnt;
  logic [BYTES_W-1:0] mul_bytes;

  rtp_lead_add #(
    .TIME_W(TIME_W), .READ_LEAD(READ_LEAD), .RESUME_LEAD(RESUME_LEAD)
  ) lead_i (
    .sel_i(lead_sel_i), .time_i(rot_time_i), .sum_o(adj_time)
  );

  rtp_recip_mul #(
    .TIME_W(TIME_W), .FRAC_W(FRAC_W), .BYTES_W(BYTES_W)
  ) mul_i (
    .clk(clk), .rst_n(rst_n), .en_i(req_i), .time_i(adj_time),
    .inv_i(inv_period_i), .bytes_i(track_bytes_i),
    .vld_o(mul_vld), .cnt_o(mul_cnt), .bytes_o(mul_bytes)
  );

  rtp_wrap_split #(
    .BIT_W(TIME_W), .BYTES_W(BYTES_W), .WORD_W(WORD_W)
  ) wrap_i (
    .clk(clk), .rst_n(rst_n), .en_i(mul_vld), .cnt_i(mul_cnt),
    .bytes_i(mul_bytes), .vld_o(res_vld_o), .pos_o(bit_pos_o),
    .woff_o(word_off_o), .bit_o(bit_in_word_o), .left_o(words_left_o)
  );
endmodule

// File: rtl/rot_track_pos_chk.sv
module rot_track_pos_chk #(
  parameter int BIT_W   = 32,
  parameter int BYTES_W = 16,
  parameter int WOFF_W  = 27,
  parameter int WSH     = 5,
  parameter int LEFT_W  = 14
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_i,
  input logic [BYTES_W-1:0] track_bytes_i,
  input logic               res_vld_o,
  input logic [BIT_W-1:0]   bit_pos_o,
  input logic [WOFF_W-1:0]  word_off_o,
  input logic [WSH-1:0]     bit_in_word_o,
  input logic [LEFT_W-1:0]  words_left_o
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!res_vld_o && bit_pos_o == '0 && words_left_o == '0));

  assert_req_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> ##1 res_vld_o);

  assert_no_orphan_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |-> $past(req_i, 2));

  assert_in_track_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |-> (bit_pos_o < (BIT_W'($past(track_bytes_i, 2)) << 3)));

  assert_split_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |-> ({word_off_o, bit_in_word_o} == bit_pos_o));

  assert_words_left_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |-> (WOFF_W'(words_left_o) + word_off_o
                   == WOFF_W'($past(track_bytes_i, 2) >> 2)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld_o |-> ($stable(bit_pos_o) && $stable(words_left_o)));
endmodule

bind rot_track_pos rot_track_pos_chk #(
  .BIT_W(TIME_W), .BYTES_W(BYTES_W), .WOFF_W(WOFF_W), .WSH(WSH), .LEFT_W(LEFT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .track_bytes_i(track_bytes_i),
  .res_vld_o(res_vld_o), .bit_pos_o(bit_pos_o), .word_off_o(word_off_o),
  .bit_in_word_o(bit_in_word_o), .words_left_o(words_left_o)
);

// File: tb/rot_track_pos_tb_top.sv
`timescale 1ns/1ps
module rot_track_pos_tb_top;
  typedef struct packed {
    logic        sel;
    logic [31:0] t;
    logic [31:0] inv;
    logic [15:0] bytes;
    logic [31:0] pos;
    logic [26:0] woff;
    logic [4:0]  bit_w;
    logic [13:0] left;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'd0,          32'h0100_0000, 16'd100,  32'd7,     27'd0,   5'd7,  14'd25},
    '{1'b1, 32'd1000,       32'h0100_0000, 16'd100,  32'd6,     27'd0,   5'd6,  14'd25},
    '{1'b0, 32'd202880,     32'h0100_0000, 16'd100,  32'd0,     27'd0,   5'd0,  14'd25},
    '{1'b0, 32'd202879,     32'h0100_0000, 16'd100,  32'd799,   27'd24,  5'd31, 14'd1},
    '{1'b1, 32'd40000,      32'h8000_0000, 16'd4096, 32'd20310, 27'd634, 5'd22, 14'd390},
    '{1'b0, 32'd60000,      32'h8000_0000, 16'd4096, 32'd30960, 27'd967, 5'd16, 14'd57},
    '{1'b1, 32'd65000,      32'h8000_0000, 16'd4096, 32'd42,    27'd1,   5'd10, 14'd1023},
    '{1'b0, 32'hFFFF_FF00,  32'h0100_0000, 16'd100,  32'd6,     27'd0,   5'd6,  14'd25},
    '{1'b0, 32'd0,          32'hFFFF_FFFF, 16'd4096, 32'd1919,  27'd59,  5'd31, 14'd965}
  };

  logic        clk;
  logic        rst_n;
  logic        req_i;
  logic        lead_sel_i;
  logic [31:0] rot_time_i;
  logic [31:0] inv_period_i;
  logic [15:0] track_bytes_i;
  logic        res_vld_o;
  logic [31:0] bit_pos_o;
  logic [26:0] word_off_o;
  logic [4:0]  bit_in_word_o;
  logic [13:0] words_left_o;

  int checks;
  int fails;
  int cycles;
  bit done;

  rot_track_pos dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .lead_sel_i(lead_sel_i),
    .rot_time_i(rot_time_i), .inv_period_i(inv_period_i),
    .track_bytes_i(track_bytes_i), .res_vld_o(res_vld_o),
    .bit_pos_o(bit_pos_o), .word_off_o(word_off_o),
    .bit_in_word_o(bit_in_word_o), .words_left_o(words_left_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_i         = 1'b1;
    lead_sel_i    = v.sel;
    rot_time_i    = v.t;
    inv_period_i  = v.inv;
    track_bytes_i = v.bytes;
  endtask

  task automatic check_vec(input vec_t v, input int idx);
    $display("vector %0d", idx);
    check("R2", "valid", 32'(res_vld_o), 32'd1);
    check("R3_R4_R5", "bit_pos", bit_pos_o, v.pos);
    check("R6", "word_off", 32'(word_off_o), 32'(v.woff));
    check("R6", "bit_in_word", 32'(bit_in_word_o), 32'(v.bit_w));
    check("R7", "words_left", 32'(words_left_o), 32'(v.left));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    checks = 0; fails = 0; cycles = 0; done = 1'b0;
    rst_n = 1'b0; req_i = 1'b0; lead_sel_i = 1'b0;
    rot_time_i = '0; inv_period_i = '0; track_bytes_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "valid in reset", 32'(res_vld_o), 32'd0);
    check("R1", "bit_pos in reset", bit_pos_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "valid after release", 32'(res_vld_o), 32'd0);
    check("R1", "words_left after release", 32'(words_left_o), 32'd0);

    // Vector table: R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      req_i = 1'b0;
      @(negedge clk);
      check_vec(VEC[i], i);
      @(negedge clk);
      check("R2", "single-cycle valid", 32'(res_vld_o), 32'd0);
    end

    // R2: back-to-back requests
    drive(VEC[4]);
    @(negedge clk);
    drive(VEC[6]);
    @(negedge clk);
    req_i = 1'b0;
    check_vec(VEC[4], 40);
    @(negedge clk);
    check_vec(VEC[6], 60);

    // R8: inputs change without a request, outputs hold
    lead_sel_i = 1'b1; rot_time_i = 32'd123456;
    inv_period_i = 32'hFFFF_FFFF; track_bytes_i = 16'd8;
    repeat (3) @(negedge clk);
    check("R8", "valid idle", 32'(res_vld_o), 32'd0);
    check("R8", "bit_pos held", bit_pos_o, 32'd42);
    check("R8", "words_left held", 32'(words_left_o), 32'd1023);

    // R1: reset mid-run clears results
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "bit_pos cleared", bit_pos_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule